// File: doc/BRIEF.md
# Control and Status Register Bank

The block is a small register bank that sits on a simple memory-mapped bus. It holds four 32-bit words at byte offsets 0x0, 0x4, 0x8 and 0xC. The bus side has an address, write data, per-byte-lane enables, a write strobe, a read strobe and a combinational read-data return. Each word is divided into bitfields. Every field has one access mode, and every field has its own hardware-side port.

The fixed map is as follows:
- **CTRL (0x0)** holds a 12-bit read/write gain field in bits [11:0] and an 8-bit write-only threshold in bits [19:12].
- **STAT (0x4)** is a 32-bit read-only status word that raises a read-notify pulse when it is read.
- **CMD (0x8)** holds a 16-bit handshake command field in bits [15:0]. A write posts request bits. The hardware clears each bit by acknowledging it.
- **LVL (0xC)** is an 8-bit read-only level in bits [7:0] that also raises a read-notify pulse.

For the read/write field, the value read back comes from a separate hardware feedback input, not from the stored copy. The CMD field follows the same rule and reads back its own status input. Bits with no field read as zero. Addresses 0x10 to 0x1F hit no register.

A parameter selects the address-selector variant. In the combinational variant, every access completes in the cycle the address is presented. In the look-ahead variant, the address input is sampled one cycle ahead of the strobes. The decoded select flags are held in flip-flops, which shortens the path from the address pins to the write enables. The control path has no sequencing states. Each access is a single cycle and is decided by the current select and strobes.

Top module: `csr_bank`

## Requirements
- R1: On a clock edge with `rst` high, `gain_out`, `thr_out` and `cmd_req` become zero. In look-ahead mode, the selects also clear, so the first cycle after reset hits no register.
- R2: A write (`wr` high) to CTRL with all four `ben` bits set loads `gain_out` from `wdata[11:0]` and `thr_out` from `wdata[19:12]` at the next rising edge. Address bits [1:0] take no part in selection.
- R3: Byte lane k covers `wdata` bits [8k+7:8k] and is written only when `ben[k]` is 1. `gain_out` spans lanes 0 and 1, and `thr_out` spans lanes 1 and 2. Each slice changes only with its own lane enable.
- R4: Reading CTRL returns `gain_fb` in bits [11:0] and zero in bits [31:12]. The write-only threshold reads back as zero.
- R5: Reading STAT returns `status_in`. Writes to STAT change no output.
- R6: Writing CMD loads `cmd_req` bits of the enabled lanes from `wdata[15:0]`. On every edge, each bit of a lane that is not being written is updated as req AND NOT `cmd_ack`. When a write and an acknowledge hit the same bit, the write wins.
- R7: Reading CMD returns `cmd_sts` in bits [15:0] and zero above.
- R8: Reading LVL returns `level_in` in bits [7:0] and zero above.
- R9: `status_rd_pulse` equals `rd` AND STAT selected, and `level_rd_pulse` equals `rd` AND LVL selected. Both are combinational.
- R10: An address with bit 4 set (0x10 to 0x1F) reads as all zeros, and a write to it changes nothing.
- R11: With `LOOKAHEAD_SEL=1`, the register selected in a cycle is the one decoded from `addr` in the previous cycle. Both read data and writes follow that select.
- R12: Without `wr` high, no stored field changes except the handshake acknowledge clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 5 | Byte address (look-ahead address in look-ahead mode) |
| wdata | input | 32 | Write data |
| ben | input | 4 | Per-byte-lane write enables |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Combinational read data |
| gain_fb | input | 12 | Read-back value of the CTRL gain field |
| gain_out | output | 12 | Stored CTRL gain |
| thr_out | output | 8 | Stored CTRL threshold (write-only) |
| status_in | input | 32 | STAT value |
| status_rd_pulse | output | 1 | High while STAT is read |
| cmd_req | output | 16 | Handshake request bits |
| cmd_ack | input | 16 | Per-bit acknowledge clearing `cmd_req` |
| cmd_sts | input | 16 | Read-back value of the CMD field |
| level_in | input | 8 | LVL value |
| level_rd_pulse | output | 1 | High while LVL is read |

## Verification
The assertions check the following properties on every cycle:
- Reset empties every stored field.
- A handshake field never gains a bit without a write.
- Plain stored fields hold when not written.
- At most one select is active.
- A read-notify pulse never appears without the read strobe.
- An unmapped address reads zero.

Some behaviours only the bench's scenarios can show. These are:
- the exact value each field takes per lane enable;
- a write winning over a simultaneous acknowledge;
- the feedback inputs being returned instead of stored copies;
- the one-cycle shift of the look-ahead selects after reset and across back-to-back accesses.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
    localparam int NUM_REGS  = 4;
    localparam int IDX_CTRL  = 0;
    localparam int IDX_STAT  = 1;
    localparam int IDX_CMD   = 2;
    localparam int IDX_LVL   = 3;
    localparam int GAIN_LSB  = 0;
    localparam int GAIN_W    = 12;
    localparam int THR_LSB   = 12;
    localparam int THR_W     = 8;
    localparam int CMD_LSB   = 0;
    localparam int CMD_W     = 16;
    localparam int LVL_LSB   = 0;
    localparam int LVL_W     = 8;
endpackage

// File: rtl/csr_decode.sv
module csr_decode #(
    parameter int ADDR_W    = 5,
    parameter int LANE_BITS = 2,
    parameter int NUM_REGS  = 4,
    parameter bit LOOKAHEAD = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel
);
    localparam int IDX_W = ADDR_W - LANE_BITS;

    logic [IDX_W-1:0]    word_idx;
    logic [NUM_REGS-1:0] hit;
    logic                unused_lane_bits;

    assign word_idx         = addr[ADDR_W-1:LANE_BITS];
    assign unused_lane_bits = ^addr[LANE_BITS-1:0];

    always_comb begin
        hit = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            hit[r] = (word_idx == IDX_W'(r));
        end
    end

    generate
        if (LOOKAHEAD) begin : g_flop_sel
            always_ff @(posedge clk) begin
                if (rst) sel <= '0;
                else     sel <= hit;
            end
        end else begin : g_comb_sel
            assign sel = hit;
        end
    endgenerate

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel)) else $error("more than one select");  // R10
endmodule

// File: rtl/csr_field.sv
module csr_field #(
    parameter int DATA_W    = 32,
    parameter int BYTE_W    = 8,
    parameter int LSB       = 0,
    parameter int WIDTH     = 8,
    parameter bit HANDSHAKE = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W/BYTE_W-1:0] ben,
    input  logic [WIDTH-1:0]         ack,
    output logic [WIDTH-1:0]         q
);
    logic unused_bits;
    assign unused_bits = ^{wdata, ben};

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            for (int i = 0; i < WIDTH; i++) begin
                if (wr_en && ben[(LSB + i) / BYTE_W]) begin
                    q[i] <= wdata[LSB + i];
                end else if (HANDSHAKE) begin
                    q[i] <= q[i] & ~ack[i];
                end
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (q == '0)) else $error("field not cleared");  // R1

    generate
        if (HANDSHAKE) begin : g_hs_chk
            AST_HS_NO_SET: assert property (@(posedge clk) disable iff (rst)
                !wr_en |=> ((q & ~$past(q)) == '0)) else $error("request set without write");  // R6
        end else begin : g_st_chk
            AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
                !wr_en |=> $stable(q)) else $error("field moved without write");  // R12
        end
    endgenerate
endmodule

// File: rtl/csr_rdmux.sv
module csr_rdmux #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4
) (
    input  logic [NUM_REGS-1:0] sel,
    input  logic [DATA_W-1:0]   words [NUM_REGS],
    output logic [DATA_W-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            rdata = rdata | (sel[r] ? words[r] : '0);
        end
    end
endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_bank_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int BYTE_W        = 8,
    parameter int ADDR_W        = 5,
    parameter bit LOOKAHEAD_SEL = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W/BYTE_W-1:0] ben,
    input  logic                     wr,
    input  logic                     rd,
    output logic [DATA_W-1:0]        rdata,
    input  logic [GAIN_W-1:0]        gain_fb,
    output logic [GAIN_W-1:0]        gain_out,
    output logic [THR_W-1:0]         thr_out,
    input  logic [DATA_W-1:0]        status_in,
    output logic                     status_rd_pulse,
    output logic [CMD_W-1:0]         cmd_req,
    input  logic [CMD_W-1:0]         cmd_ack,
    input  logic [CMD_W-1:0]         cmd_sts,
    input  logic [LVL_W-1:0]         level_in,
    output logic                     level_rd_pulse
);
    localparam int LANES     = DATA_W / BYTE_W;
    localparam int LANE_BITS = $clog2(LANES);

    logic [NUM_REGS-1:0] sel;
    logic [DATA_W-1:0]   words [NUM_REGS];

    csr_decode #(
        .ADDR_W(ADDR_W), .LANE_BITS(LANE_BITS),
        .NUM_REGS(NUM_REGS), .LOOKAHEAD(LOOKAHEAD_SEL)
    ) u_decode (
        .clk(clk), .rst(rst), .addr(addr), .sel(sel)
    );

    csr_field #(
        .DATA_W(DATA_W), .BYTE_W(BYTE_W), .LSB(GAIN_LSB),
        .WIDTH(GAIN_W), .HANDSHAKE(1'b0)
    ) u_gain (
        .clk(clk), .rst(rst), .wr_en(sel[IDX_CTRL] & wr), .wdata(wdata),
        .ben(ben), .ack('0), .q(gain_out)
    );

    csr_field #(
        .DATA_W(DATA_W), .BYTE_W(BYTE_W), .LSB(THR_LSB),
        .WIDTH(THR_W), .HANDSHAKE(1'b0)
    ) u_thr (
        .clk(clk), .rst(rst), .wr_en(sel[IDX_CTRL] & wr), .wdata(wdata),
        .ben(ben), .ack('0), .q(thr_out)
    );

    csr_field #(
        .DATA_W(DATA_W), .BYTE_W(BYTE_W), .LSB(CMD_LSB),
        .WIDTH(CMD_W), .HANDSHAKE(1'b1)
    ) u_cmd (
        .clk(clk), .rst(rst), .wr_en(sel[IDX_CMD] & wr), .wdata(wdata),
        .ben(ben), .ack(cmd_ack), .q(cmd_req)
    );

    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) words[r] = '0;
        words[IDX_CTRL][GAIN_LSB +: GAIN_W] = gain_fb;
        words[IDX_STAT]                     = status_in;
        words[IDX_CMD][CMD_LSB +: CMD_W]    = cmd_sts;
        words[IDX_LVL][LVL_LSB +: LVL_W]    = level_in;
    end

    csr_rdmux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rdmux (
        .sel(sel), .words(words), .rdata(rdata)
    );

    assign status_rd_pulse = sel[IDX_STAT] & rd;
    assign level_rd_pulse  = sel[IDX_LVL] & rd;

    AST_NOTIFY_NEEDS_RD: assert property (@(posedge clk) disable iff (rst)
        (status_rd_pulse || level_rd_pulse) |-> rd) else $error("notify without read");  // R9

    generate
        if (!LOOKAHEAD_SEL) begin : g_unmapped_chk
            AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
                (int'(addr[ADDR_W-1:LANE_BITS]) >= NUM_REGS) |-> (rdata == '0))
                else $error("unmapped read not zero");  // R10
        end
    endgenerate
endmodule

// File: tb/csr_bank_bench.sv
module csr_bank_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        rst;
        logic [4:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  ben;
        logic        wr;
        logic        rd;
        logic [15:0] ack;
    } op_t;

    op_t   ops [$];
    string tags [$];

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // shared stimulus
    logic        rst = 1'b1;
    logic [4:0]  addr0 = '0, addr1 = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  ben = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [11:0] gain_fb = '0;
    logic [31:0] status_in = '0;
    logic [15:0] cmd_ack = '0, cmd_sts = '0;
    logic [7:0]  level_in = '0;
    string       cur_tag = "R1";
    bit          running = 1'b0;

    logic [31:0] rdata [2];
    logic [11:0] gain_out [2];
    logic [7:0]  thr_out [2];
    logic [15:0] cmd_req [2];
    logic        st_p [2], lv_p [2];

    csr_bank #(.LOOKAHEAD_SEL(1'b0)) u_csr_bank (
        .clk(clk), .rst(rst), .addr(addr0), .wdata(wdata), .ben(ben), .wr(wr), .rd(rd),
        .rdata(rdata[0]), .gain_fb(gain_fb), .gain_out(gain_out[0]), .thr_out(thr_out[0]),
        .status_in(status_in), .status_rd_pulse(st_p[0]), .cmd_req(cmd_req[0]),
        .cmd_ack(cmd_ack), .cmd_sts(cmd_sts), .level_in(level_in), .level_rd_pulse(lv_p[0])
    );

    csr_bank #(.LOOKAHEAD_SEL(1'b1)) u_csr_bank_la (
        .clk(clk), .rst(rst), .addr(addr1), .wdata(wdata), .ben(ben), .wr(wr), .rd(rd),
        .rdata(rdata[1]), .gain_fb(gain_fb), .gain_out(gain_out[1]), .thr_out(thr_out[1]),
        .status_in(status_in), .status_rd_pulse(st_p[1]), .cmd_req(cmd_req[1]),
        .cmd_ack(cmd_ack), .cmd_sts(cmd_sts), .level_in(level_in), .level_rd_pulse(lv_p[1])
    );

    // reference model state, one copy per instance
    logic [19:0] m_ctl [2];
    logic [15:0] m_cmd [2];
    int          m_sel1 = -1;
    int          n_chk = 0, n_bad = 0;

    initial begin
        m_ctl[0] = '0; m_ctl[1] = '0; m_cmd[0] = '0; m_cmd[1] = '0;
    end

    function automatic int decode(logic [4:0] a);
        return (a[4] == 1'b0) ? int'(a[3:2]) : -1;
    endfunction

    function automatic logic [31:0] word_of(int s);
        case (s)
            0: return {20'b0, gain_fb};
            1: return status_in;
            2: return {16'b0, cmd_sts};
            3: return {24'b0, level_in};
            default: return 32'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (running) begin
            for (int d = 0; d < 2; d++) begin
                int s;
                s = (d == 0) ? decode(addr0) : m_sel1;
                if (rst) begin
                    m_ctl[d] = '0;
                    m_cmd[d] = '0;
                end else begin
                    for (int i = 0; i < 20; i++)
                        if (wr && s == 0 && ben[i/8]) m_ctl[d][i] = wdata[i];
                    for (int i = 0; i < 16; i++)
                        if (wr && s == 2 && ben[i/8]) m_cmd[d][i] = wdata[i];
                        else m_cmd[d][i] = m_cmd[d][i] & ~cmd_ack[i];
                end
            end
            m_sel1 = rst ? -1 : decode(addr1);
        end
    end

    task automatic chk(string what, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            for (int d = 0; d < 2; d++) begin
                int    s;
                string t;
                s = (d == 0) ? decode(addr0) : m_sel1;
                t = (d == 0) ? cur_tag : {cur_tag, " R11"};
                chk("rdata",    t, rdata[d], word_of(s));
                chk("gain_out", t, 32'(gain_out[d]), 32'(m_ctl[d][11:0]));
                chk("thr_out",  t, 32'(thr_out[d]),  32'(m_ctl[d][19:12]));
                chk("cmd_req",  t, 32'(cmd_req[d]),  32'(m_cmd[d]));
                chk("status_rd_pulse R9", t, 32'(st_p[d]), 32'(rd && s == 1));
                chk("level_rd_pulse R9",  t, 32'(lv_p[d]), 32'(rd && s == 3));
            end
        end
    end

    task automatic add(logic r, logic [4:0] a, logic [31:0] wd, logic [3:0] be,
                       logic w, logic rr, logic [15:0] ak, string tag);
        op_t o;
        o.rst = r; o.addr = a; o.wdata = wd; o.ben = be; o.wr = w; o.rd = rr; o.ack = ak;
        ops.push_back(o);
        tags.push_back(tag);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset with busy bus
        add(1, 5'h00, 32'hFFFF_FFFF, 4'hF, 1, 1, 16'h0000, "R1");
        add(1, 5'h08, 32'hFFFF_FFFF, 4'hF, 1, 1, 16'h0000, "R1");
        add(1, 5'h00, 32'h0, 4'h0, 0, 0, 16'h0000, "R1");
        add(0, 5'h00, 32'h0, 4'h0, 0, 1, 16'h0000, "R1");              // look-ahead first cycle
        add(0, 5'h00, 32'h0, 4'h0, 0, 1, 16'h0000, "R4");
        // R2: full write, low address bits ignored
        add(0, 5'h00, 32'hABCD_E123, 4'hF, 1, 0, 16'h0000, "R2");
        add(0, 5'h03, 32'h0, 4'h0, 0, 1, 16'h0000, "R2");
        add(0, 5'h02, 32'h1234_5678, 4'hF, 1, 0, 16'h0000, "R2");
        // R3: lane by lane
        add(0, 5'h01, 32'h0000_5A00, 4'h2, 1, 0, 16'h0000, "R3");
        add(0, 5'h00, 32'h00C3_0000, 4'h4, 1, 0, 16'h0000, "R3");
        add(0, 5'h00, 32'hFFFF_FFFF, 4'h1, 1, 0, 16'h0000, "R3");
        add(0, 5'h00, 32'h0000_0000, 4'h0, 1, 0, 16'h0000, "R3");
        add(0, 5'h00, 32'h0000_0000, 4'h8, 1, 1, 16'h0000, "R3");
        // R12: strobes low
        add(0, 5'h00, 32'h0, 4'hF, 0, 0, 16'h0000, "R12");
        add(0, 5'h08, 32'h0, 4'hF, 0, 1, 16'h0000, "R12");
        // R5/R9: status read and ignored write
        add(0, 5'h04, 32'hFFFF_FFFF, 4'hF, 1, 0, 16'h0000, "R5");
        add(0, 5'h04, 32'h0, 4'h0, 0, 1, 16'h0000, "R5");
        add(0, 5'h07, 32'h0, 4'h0, 0, 1, 16'h0000, "R9");
        // R6/R7: handshake
        add(0, 5'h08, 32'hFFFF_FFFF, 4'hF, 1, 0, 16'h0000, "R6");
        add(0, 5'h08, 32'h0, 4'h0, 0, 1, 16'h0F0F, "R6");
        add(0, 5'h0C, 32'h0, 4'h0, 0, 0, 16'h0030, "R6");
        add(0, 5'h08, 32'h0000_00FF, 4'h1, 1, 0, 16'hFF00, "R6");       // lane1 acks, lane0 written
        add(0, 5'h08, 32'h0000_AA00, 4'h2, 1, 0, 16'hFFFF, "R6");       // write wins over ack
        add(0, 5'h08, 32'h0, 4'h0, 0, 1, 16'h0000, "R7");
        add(0, 5'h08, 32'h0, 4'h0, 0, 1, 16'hFFFF, "R7");
        // R8/R9: level
        add(0, 5'h0C, 32'hFFFF_FFFF, 4'hF, 1, 1, 16'h0000, "R8");
        add(0, 5'h0D, 32'h0, 4'h0, 0, 1, 16'h0000, "R8");
        // R10: unmapped
        add(0, 5'h10, 32'hFFFF_FFFF, 4'hF, 1, 1, 16'h0000, "R10");
        add(0, 5'h14, 32'hFFFF_FFFF, 4'hF, 1, 1, 16'h0000, "R10");
        add(0, 5'h18, 32'h0, 4'h0, 0, 1, 16'h0000, "R10");
        add(0, 5'h1C, 32'h0, 4'h0, 0, 1, 16'h0000, "R10");
        // R11: back-to-back address changes
        for (int k = 0; k < 8; k++)
            add(0, 5'(k * 4), 32'h3C3C_3C3C ^ 32'(k), 4'hF, k[0], 1, 16'(k), "R11");
        add(1, 5'h00, 32'h0, 4'h0, 0, 0, 16'h0000, "R1");
        add(0, 5'h00, 32'h0, 4'h0, 0, 1, 16'h0000, "R1");

        for (int k = 0; k < ops.size(); k++) begin
            rst       = ops[k].rst;
            addr0     = ops[k].addr;
            addr1     = (k + 1 < ops.size()) ? ops[k+1].addr : 5'h00;
            wdata     = ops[k].wdata;
            ben       = ops[k].ben;
            wr        = ops[k].wr;
            rd        = ops[k].rd;
            cmd_ack   = ops[k].ack;
            gain_fb   = 12'(k * 37 + 5);
            status_in = 32'h9E37_79B9 * 32'(k + 1);
            cmd_sts   = 16'(k * 911 + 3);
            level_in  = 8'(k * 13 + 1);
            cur_tag   = tags[k];
            running   = 1'b1;
            @(posedge clk);
            #1;
        end
        running = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule